// File: doc/BRIEF.md
# Register Field Storage Core

This block keeps the stored value of one register field and decides, every clock, what that value becomes next. Two parties act on it. Software reaches it through a decoded access strobe with write data and per-bit write strobes. Hardware reaches it through a write port, optional set and clear inputs, and optional up and down counting. When both act in the same cycle, a fixed ranking picks the winner. A parameter chooses whether software or hardware holds the upper hand.

The field drives its value, the AND, OR and XOR reductions of that value, and two strobes. One strobe marks any software access and the other marks a software access that modifies the field. In counter mode the field saturates at both ends. Each saturation is reported by a one-cycle pulse. A read that clears a counter never discards a count that arrives in the same cycle. Address decode and bus protocol belong to the surrounding register block.

Top module: `regfield_core`

## Requirements
- R1: While `rst_n` is low, `value` takes `RESET_VAL` without waiting for a clock edge, and `ovf_pulse` and `unf_pulse` are 0. This field reset is separate from any bus-side reset.
- R2: A software write is `sw_req`=1 with `sw_is_wr`=1. Only bits whose `sw_wmask` bit is 1 are affected. With `SW_WR_MODE`=SWW_PLAIN those bits take `sw_wdata`. With SWW_ONE_CLR the bits where `sw_wdata` is 1 are cleared. With SWW_ONE_SET those bits are set. With SWW_NONE a write has no effect. A write whose mask is all zero leaves `value` unchanged.
- R3: When `SW_PRIO`=1, a software write or clearing read beats any hardware action in the same cycle. When `SW_PRIO`=0, hardware write, set, clear and counting all beat a software access.
- R4: The hardware write takes effect when `hw_we` is 1 if `WE_ACTIVE_LOW`=0, and when `hw_we` is 0 if `WE_ACTIVE_LOW`=1. It loads `hw_wdata`.
- R5: When `HAS_CLR`=1, `hw_clr` forces all zeros. When `HAS_SET`=1, `hw_set` forces all ones. Clear beats set, and set beats a hardware write. When a control is disabled by its parameter, its input is ignored.
- R6: A hardware write, set or clear in the same cycle as counting wins, and that cycle's count is dropped.
- R7: With `COUNTER`=1, `cnt_inc` adds the step and `cnt_dec` subtracts the step. When both are asserted, the net result is applied. A step is the `cnt_inc_step`/`cnt_dec_step` input when `INC_WIDTH`/`DEC_WIDTH` is above 0, and a constant 1 otherwise. With no access of any kind, `value` holds.
- R8: A count result above all ones saturates at all ones and pulses `ovf_pulse` for one cycle. A result below zero saturates at zero and pulses `unf_pulse` for one cycle. Each pulse appears on the same edge as the saturated value.
- R9: With `RD_CLEAR`=1, a software read (`sw_req`=1, `sw_is_wr`=0) clears the field. If counting occurs in the same cycle, the field becomes the count applied to zero. With `RD_CLEAR`=0, a read leaves `value` unchanged.
- R10: `red_and`, `red_or` and `red_xor` are the AND, OR and XOR of all bits of `value`, with no added delay.
- R11: `sw_acc_pulse` equals `sw_req` in the same cycle. `sw_mod_pulse` is 1 in the same cycle as a software write with a nonzero mask (mode not SWW_NONE) or a clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Field reset, asynchronous, active low |
| sw_req | input | 1 | Decoded software access strobe |
| sw_is_wr | input | 1 | 1 for a write, 0 for a read |
| sw_wdata | input | WIDTH | Software write data |
| sw_wmask | input | WIDTH | Per-bit write strobes |
| hw_we | input | 1 | Hardware write enable, polarity per WE_ACTIVE_LOW |
| hw_wdata | input | WIDTH | Hardware write data |
| hw_set | input | 1 | Force all ones (HAS_SET) |
| hw_clr | input | 1 | Force all zeros (HAS_CLR) |
| cnt_inc | input | 1 | Count up |
| cnt_inc_step | input | max(INC_WIDTH,1) | Up step when INC_WIDTH>0 |
| cnt_dec | input | 1 | Count down |
| cnt_dec_step | input | max(DEC_WIDTH,1) | Down step when DEC_WIDTH>0 |
| value | output | WIDTH | Stored field value |
| red_and | output | 1 | AND of value |
| red_or | output | 1 | OR of value |
| red_xor | output | 1 | XOR of value |
| sw_acc_pulse | output | 1 | Software accessed the field |
| sw_mod_pulse | output | 1 | Software modified the field |
| ovf_pulse | output | 1 | Up count saturated |
| unf_pulse | output | 1 | Down count saturated |

## Verification
The precedence chain is tested with colliding inputs. A software write is paired with a hardware write, a hardware write with a count, and a set with a clear. Each pairing shows which rank wins and whether the two sides of the software-precedence choice are ordered correctly. Counting is driven with an input step, the constant step, simultaneous up and down, and runs past both ends. These show net arithmetic and saturation apart from plain wrapping. A clearing read arrives together with an increment, and another clearing read arrives alone, to show that the read clears without eating the count. A zero-mask write, a read with clearing disabled, and a disabled set input show that the field holds still when it should.

// File: rtl/regfield_pkg.sv
package regfield_pkg;

   // Effect of a software write on the bits selected by the write mask
   typedef enum logic [1:0] {
      SWW_NONE    = 2'd0,
      SWW_PLAIN   = 2'd1,
      SWW_ONE_CLR = 2'd2,
      SWW_ONE_SET = 2'd3
   } sw_wr_mode_e;

endpackage

// File: rtl/regfield_sw_path.sv
module regfield_sw_path
   import regfield_pkg::*;
#(
   parameter int          WIDTH      = 8,
   parameter sw_wr_mode_e SW_WR_MODE = SWW_PLAIN,
   parameter bit          RD_CLEAR   = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             req,
   input  logic             is_wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] wmask,
   output logic             wr_hit,
   output logic             rdclr_hit,
   output logic [WIDTH-1:0] nxt
);

   logic [WIDTH-1:0] wr_val;
   logic             can_write;

   generate
      if (SW_WR_MODE == SWW_PLAIN) begin : g_plain
         assign wr_val    = (cur & ~wmask) | (wdata & wmask);
         assign can_write = 1'b1;
      end else if (SW_WR_MODE == SWW_ONE_CLR) begin : g_one_clr
         assign wr_val    = cur & ~(wdata & wmask);
         assign can_write = 1'b1;
      end else if (SW_WR_MODE == SWW_ONE_SET) begin : g_one_set
         assign wr_val    = cur | (wdata & wmask);
         assign can_write = 1'b1;
      end else begin : g_no_write
         assign wr_val    = cur;
         assign can_write = 1'b0;
      end

      if (RD_CLEAR) begin : g_rdclr
         assign rdclr_hit = req & ~is_wr;
      end else begin : g_no_rdclr
         assign rdclr_hit = 1'b0;
      end
   endgenerate

   assign wr_hit = can_write & req & is_wr & (|wmask);
   assign nxt    = rdclr_hit ? '0 : wr_val;

endmodule

// File: rtl/regfield_hw_path.sv
module regfield_hw_path #(
   parameter int WIDTH         = 8,
   parameter bit WE_ACTIVE_LOW = 1'b0,
   parameter bit HAS_SET       = 1'b1,
   parameter bit HAS_CLR       = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   input  logic             set,
   input  logic             clr,
   output logic             act,
   output logic [WIDTH-1:0] nxt
);

   logic we_on, set_on, clr_on;

   generate
      if (WE_ACTIVE_LOW) begin : g_we_low
         assign we_on = ~we;
      end else begin : g_we_high
         assign we_on = we;
      end

      if (HAS_SET) begin : g_set
         assign set_on = set;
      end else begin : g_no_set
         assign set_on = 1'b0;
      end

      if (HAS_CLR) begin : g_clr
         assign clr_on = clr;
      end else begin : g_no_clr
         assign clr_on = 1'b0;
      end
   endgenerate

   // Within the hardware rank: clear, then set, then write
   always_comb begin
      if (clr_on)      nxt = '0;
      else if (set_on) nxt = '1;
      else if (we_on)  nxt = wdata;
      else             nxt = cur;
   end

   assign act = we_on | set_on | clr_on;

endmodule

// File: rtl/regfield_counter.sv
module regfield_counter #(
   parameter  int WIDTH     = 8,
   parameter  int INC_WIDTH = 4,
   parameter  int DEC_WIDTH = 4,
   localparam int IPW       = (INC_WIDTH > 0) ? INC_WIDTH : 1,
   localparam int DPW       = (DEC_WIDTH > 0) ? DEC_WIDTH : 1
) (
   input  logic [WIDTH-1:0] base,
   input  logic             inc,
   input  logic [IPW-1:0]   inc_step,
   input  logic             dec,
   input  logic [DPW-1:0]   dec_step,
   output logic [WIDTH-1:0] res,
   output logic             ovf,
   output logic             unf
);

   // Two guard bits: one for carry out, one as sign for borrow
   localparam int EW = WIDTH + 2;

   logic [EW-1:0] up_amt, dn_amt, sum;

   generate
      if (INC_WIDTH == 0) begin : g_inc_one
         assign up_amt = EW'(1);
      end else begin : g_inc_in
         assign up_amt = {{(EW-IPW){1'b0}}, inc_step};
      end

      if (DEC_WIDTH == 0) begin : g_dec_one
         assign dn_amt = EW'(1);
      end else begin : g_dec_in
         assign dn_amt = {{(EW-DPW){1'b0}}, dec_step};
      end
   endgenerate

   always_comb begin
      sum = {2'b00, base} + (inc ? up_amt : '0) - (dec ? dn_amt : '0);
      ovf = 1'b0;
      unf = 1'b0;
      res = sum[WIDTH-1:0];
      if (sum[EW-1]) begin
         res = '0;
         unf = 1'b1;
      end else if (sum[WIDTH]) begin
         res = '1;
         ovf = 1'b1;
      end
   end

endmodule

// File: rtl/regfield_core.sv
module regfield_core
   import regfield_pkg::*;
#(
   parameter  int               WIDTH         = 8,
   parameter  logic [WIDTH-1:0] RESET_VAL     = '0,
   parameter  bit               SW_PRIO       = 1'b1,
   parameter  bit               WE_ACTIVE_LOW = 1'b0,
   parameter  bit               HAS_SET       = 1'b1,
   parameter  bit               HAS_CLR       = 1'b1,
   parameter  bit               COUNTER       = 1'b1,
   parameter  int               INC_WIDTH     = 4,
   parameter  int               DEC_WIDTH     = 4,
   parameter  sw_wr_mode_e      SW_WR_MODE    = SWW_PLAIN,
   parameter  bit               RD_CLEAR      = 1'b1,
   localparam int               IPW           = (INC_WIDTH > 0) ? INC_WIDTH : 1,
   localparam int               DPW           = (DEC_WIDTH > 0) ? DEC_WIDTH : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_req,
   input  logic             sw_is_wr,
   input  logic [WIDTH-1:0] sw_wdata,
   input  logic [WIDTH-1:0] sw_wmask,
   input  logic             hw_we,
   input  logic [WIDTH-1:0] hw_wdata,
   input  logic             hw_set,
   input  logic             hw_clr,
   input  logic             cnt_inc,
   input  logic [IPW-1:0]   cnt_inc_step,
   input  logic             cnt_dec,
   input  logic [DPW-1:0]   cnt_dec_step,
   output logic [WIDTH-1:0] value,
   output logic             red_and,
   output logic             red_or,
   output logic             red_xor,
   output logic             sw_acc_pulse,
   output logic             sw_mod_pulse,
   output logic             ovf_pulse,
   output logic             unf_pulse
);

   // Elaboration-time parameter checks
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("regfield_core: WIDTH must be at least 1");
      end
      if (INC_WIDTH < 0 || INC_WIDTH > WIDTH) begin : g_bad_inc
         $error("regfield_core: INC_WIDTH must lie in 0..WIDTH");
      end
      if (DEC_WIDTH < 0 || DEC_WIDTH > WIDTH) begin : g_bad_dec
         $error("regfield_core: DEC_WIDTH must lie in 0..WIDTH");
      end
   endgenerate

   logic             sw_wr_hit, sw_rdclr_hit, sw_hit;
   logic [WIDTH-1:0] sw_nxt;
   logic             hw_act;
   logic [WIDTH-1:0] hw_nxt;
   logic             cnt_act, cnt_ovf, cnt_unf;
   logic [WIDTH-1:0] cnt_base, cnt_res;
   logic [WIDTH-1:0] nxt;
   logic             nxt_ovf, nxt_unf;

   regfield_sw_path #(
      .WIDTH      (WIDTH),
      .SW_WR_MODE (SW_WR_MODE),
      .RD_CLEAR   (RD_CLEAR)
   ) u_sw (
      .cur       (value),
      .req       (sw_req),
      .is_wr     (sw_is_wr),
      .wdata     (sw_wdata),
      .wmask     (sw_wmask),
      .wr_hit    (sw_wr_hit),
      .rdclr_hit (sw_rdclr_hit),
      .nxt       (sw_nxt)
   );

   regfield_hw_path #(
      .WIDTH         (WIDTH),
      .WE_ACTIVE_LOW (WE_ACTIVE_LOW),
      .HAS_SET       (HAS_SET),
      .HAS_CLR       (HAS_CLR)
   ) u_hw (
      .cur   (value),
      .we    (hw_we),
      .wdata (hw_wdata),
      .set   (hw_set),
      .clr   (hw_clr),
      .act   (hw_act),
      .nxt   (hw_nxt)
   );

   // A clearing read restarts the count from zero instead of discarding it
   assign cnt_base = sw_rdclr_hit ? '0 : value;

   generate
      if (COUNTER) begin : g_cnt
         regfield_counter #(
            .WIDTH     (WIDTH),
            .INC_WIDTH (INC_WIDTH),
            .DEC_WIDTH (DEC_WIDTH)
         ) u_cnt (
            .base     (cnt_base),
            .inc      (cnt_inc),
            .inc_step (cnt_inc_step),
            .dec      (cnt_dec),
            .dec_step (cnt_dec_step),
            .res      (cnt_res),
            .ovf      (cnt_ovf),
            .unf      (cnt_unf)
         );
         assign cnt_act = cnt_inc | cnt_dec;
      end else begin : g_no_cnt
         assign cnt_res = cnt_base;
         assign cnt_ovf = 1'b0;
         assign cnt_unf = 1'b0;
         assign cnt_act = 1'b0;
      end
   endgenerate

   assign sw_hit = sw_wr_hit | sw_rdclr_hit;

   // Ranked next-value selection; reset is handled in the flop
   always_comb begin
      nxt     = value;
      nxt_ovf = 1'b0;
      nxt_unf = 1'b0;
      if (SW_PRIO && sw_hit) begin
         if (sw_rdclr_hit && cnt_act) begin
            nxt     = cnt_res;
            nxt_ovf = cnt_ovf;
            nxt_unf = cnt_unf;
         end else begin
            nxt = sw_nxt;
         end
      end else if (hw_act) begin
         nxt = hw_nxt;
      end else if (cnt_act) begin
         nxt     = cnt_res;
         nxt_ovf = cnt_ovf;
         nxt_unf = cnt_unf;
      end else if (sw_hit) begin
         nxt = sw_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value     <= RESET_VAL;
         ovf_pulse <= 1'b0;
         unf_pulse <= 1'b0;
      end else begin
         value     <= nxt;
         ovf_pulse <= nxt_ovf;
         unf_pulse <= nxt_unf;
      end
   end

   assign red_and      = &value;
   assign red_or       = |value;
   assign red_xor      = ^value;
   assign sw_acc_pulse = sw_req;
   assign sw_mod_pulse = sw_hit;

endmodule

// File: rtl/regfield_core_chk.sv
module regfield_core_chk #(
   parameter  int               WIDTH         = 8,
   parameter  logic [WIDTH-1:0] RESET_VAL     = '0,
   parameter  bit               WE_ACTIVE_LOW = 1'b0,
   parameter  bit               HAS_SET       = 1'b1,
   parameter  bit               HAS_CLR       = 1'b1,
   parameter  bit               COUNTER       = 1'b1,
   parameter  int               INC_WIDTH     = 4,
   parameter  bit               RD_CLEAR      = 1'b1,
   localparam int               IPW           = (INC_WIDTH > 0) ? INC_WIDTH : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_req,
   input logic             sw_is_wr,
   input logic             hw_we,
   input logic             hw_set,
   input logic             hw_clr,
   input logic             cnt_inc,
   input logic [IPW-1:0]   cnt_inc_step,
   input logic             cnt_dec,
   input logic [WIDTH-1:0] value,
   input logic             sw_acc_pulse,
   input logic             sw_mod_pulse,
   input logic             ovf_pulse,
   input logic             unf_pulse
);

   logic hw_any, cnt_any;
   assign hw_any  = (WE_ACTIVE_LOW ? !hw_we : hw_we) || (HAS_SET && hw_set) || (HAS_CLR && hw_clr);
   assign cnt_any = COUNTER && (cnt_inc || cnt_dec);

   a_r1_reset_value: assert property (@(posedge clk) !rst_n |=> value == RESET_VAL);

   a_r8_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> value == '1);

   a_r8_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
      unf_pulse |-> value == '0);

   a_r8_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_pulse && unf_pulse));

   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_req && !hw_any && !cnt_any) |=> $stable(value));

   a_r11_mod_needs_acc: assert property (@(posedge clk) disable iff (!rst_n)
      sw_mod_pulse |-> sw_acc_pulse);

   generate
      if (COUNTER && RD_CLEAR) begin : g_rdclr_cnt
         a_r9_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_req && !sw_is_wr && cnt_inc && !cnt_dec && !hw_any &&
             (INC_WIDTH == 0 || cnt_inc_step != '0)) |=> value != '0);
      end
   endgenerate

endmodule

bind regfield_core regfield_core_chk #(
   .WIDTH         (WIDTH),
   .RESET_VAL     (RESET_VAL),
   .WE_ACTIVE_LOW (WE_ACTIVE_LOW),
   .HAS_SET       (HAS_SET),
   .HAS_CLR       (HAS_CLR),
   .COUNTER       (COUNTER),
   .INC_WIDTH     (INC_WIDTH),
   .RD_CLEAR      (RD_CLEAR)
) u_chk (.*);

// File: tb/regfield_core_bench.sv
`timescale 1ns/1ps
module regfield_core_bench;
   import regfield_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // ---- main instance: software precedence, input up step, unit down step
   logic       sw_req, sw_is_wr, hw_we, hw_set, hw_clr, cnt_inc, cnt_dec;
   logic [7:0] sw_wdata, sw_wmask, hw_wdata, value;
   logic [3:0] cnt_inc_step;
   logic [0:0] cnt_dec_step;
   logic       red_and, red_or, red_xor, acc, mod, ovf, unf;

   regfield_core #(
      .WIDTH(8), .RESET_VAL(8'h5A), .SW_PRIO(1'b1), .WE_ACTIVE_LOW(1'b0),
      .HAS_SET(1'b1), .HAS_CLR(1'b1), .COUNTER(1'b1), .INC_WIDTH(4),
      .DEC_WIDTH(0), .SW_WR_MODE(SWW_PLAIN), .RD_CLEAR(1'b1)
   ) u_regfield_core (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_is_wr(sw_is_wr),
      .sw_wdata(sw_wdata), .sw_wmask(sw_wmask), .hw_we(hw_we), .hw_wdata(hw_wdata),
      .hw_set(hw_set), .hw_clr(hw_clr), .cnt_inc(cnt_inc), .cnt_inc_step(cnt_inc_step),
      .cnt_dec(cnt_dec), .cnt_dec_step(cnt_dec_step), .value(value),
      .red_and(red_and), .red_or(red_or), .red_xor(red_xor),
      .sw_acc_pulse(acc), .sw_mod_pulse(mod), .ovf_pulse(ovf), .unf_pulse(unf)
   );

   // ---- second instance: hardware precedence, active-low enable, no set/clear
   logic       b_req, b_wr, b_we_n, b_set, b_clr, b_inc, b_dec;
   logic [7:0] b_wd, b_wm, b_hd, b_value;
   logic [0:0] b_is, b_ds;
   logic       b_rand, b_ror, b_rxor, b_acc, b_mod, b_ovf, b_unf;

   regfield_core #(
      .WIDTH(8), .RESET_VAL(8'h0F), .SW_PRIO(1'b0), .WE_ACTIVE_LOW(1'b1),
      .HAS_SET(1'b0), .HAS_CLR(1'b0), .COUNTER(1'b1), .INC_WIDTH(0),
      .DEC_WIDTH(0), .SW_WR_MODE(SWW_ONE_CLR), .RD_CLEAR(1'b0)
   ) u_regfield_core_hp (
      .clk(clk), .rst_n(rst_n), .sw_req(b_req), .sw_is_wr(b_wr),
      .sw_wdata(b_wd), .sw_wmask(b_wm), .hw_we(b_we_n), .hw_wdata(b_hd),
      .hw_set(b_set), .hw_clr(b_clr), .cnt_inc(b_inc), .cnt_inc_step(b_is),
      .cnt_dec(b_dec), .cnt_dec_step(b_ds), .value(b_value),
      .red_and(b_rand), .red_or(b_ror), .red_xor(b_rxor),
      .sw_acc_pulse(b_acc), .sw_mod_pulse(b_mod), .ovf_pulse(b_ovf), .unf_pulse(b_unf)
   );

   typedef struct packed {
      logic       req, wr;
      logic [7:0] wd, wm;
      logic       we;
      logic [7:0] hd;
      logic       st, cl, inc;
      logic [3:0] istep;
      logic       dec;
      logic [7:0] ev;
      logic       eo, eu, ea, em;
   } vec_t;

   localparam int NV = 16;
   //  req  wr    wd     wm   we    hd   set  clr  inc  step dec     exp  ovf  unf  acc  mod
   localparam vec_t VECS [NV] = '{
      {1'b1,1'b1,8'hFF,8'h0F,1'b0,8'h00,1'b0,1'b0,1'b0,4'd0,1'b0, 8'h5F,1'b0,1'b0,1'b1,1'b1},
      {1'b0,1'b0,8'h00,8'h00,1'b1,8'h33,1'b0,1'b0,1'b0,4'd0,1'b0, 8'h33,1'b0,1'b0,1'b0,1'b0},
      {1'b1,1'b1,8'h00,8'hFF,1'b1,8'h77,1'b0,1'b0,1'b0,4'd0,1'b0, 8'h00,1'b0,1'b0,1'b1,1'b1},
      {1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,1'b0,1'b1,4'd5,1'b0, 8'h05,1'b0,1'b0,1'b0,1'b0},
      {1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,1'b0,1'b1,4'd3,1'b1, 8'h07,1'b0,1'b0,1'b0,1'b0},
      {1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b1,1'b0,1'b0,4'd0,1'b0, 8'hFF,1'b0,1'b0,1'b0,1'b0},
      {1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,1'b0,1'b1,4'd2,1'b0, 8'hFF,1'b1,1'b0,1'b0,1'b0},
      {1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,4'd0,1'b1, 8'hFE,1'b0,1'b0,1'b0,1'b0},
      {1'b0,1'b0,8'h00,8'h00,1'b1,8'h12,1'b1,1'b1,1'b0,4'd0,1'b0, 8'h00,1'b0,1'b0,1'b0,1'b0},
      {1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,4'd0,1'b1, 8'h00,1'b0,1'b1,1'b0,1'b0},
      {1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,1'b0,1'b1,4'd9,1'b0, 8'h09,1'b0,1'b0,1'b0,1'b0},
      {1'b1,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,1'b0,1'b1,4'd4,1'b0, 8'h04,1'b0,1'b0,1'b1,1'b1},
      {1'b1,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,4'd0,1'b0, 8'h00,1'b0,1'b0,1'b1,1'b1},
      {1'b0,1'b0,8'h00,8'h00,1'b1,8'hA5,1'b0,1'b0,1'b1,4'd1,1'b0, 8'hA5,1'b0,1'b0,1'b0,1'b0},
      {1'b1,1'b1,8'hFF,8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,4'd0,1'b0, 8'hA5,1'b0,1'b0,1'b1,1'b0},
      {1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,4'd0,1'b0, 8'hA5,1'b0,1'b0,1'b0,1'b0}
   };

   string vtag [NV];

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle_all();
      sw_req = 0; sw_is_wr = 0; sw_wdata = '0; sw_wmask = '0;
      hw_we = 0; hw_wdata = '0; hw_set = 0; hw_clr = 0;
      cnt_inc = 0; cnt_inc_step = '0; cnt_dec = 0; cnt_dec_step = '0;
      b_req = 0; b_wr = 0; b_wd = '0; b_wm = '0; b_we_n = 1; b_hd = '0;
      b_set = 0; b_clr = 0; b_inc = 0; b_dec = 0; b_is = '0; b_ds = '0;
   endtask

   task automatic check_red(input logic [7:0] ev);
      check("R10", "red_and", {31'd0, red_and}, {31'd0, &ev});
      check("R10", "red_or",  {31'd0, red_or},  {31'd0, |ev});
      check("R10", "red_xor", {31'd0, red_xor}, {31'd0, ^ev});
   endtask

   initial begin
      vtag = '{"R2","R4","R3","R7","R7","R5","R8","R7","R5","R8","R7","R9","R9","R6","R2","R7"};
      idle_all();
      repeat (3) @(negedge clk);
      // R1: reset state of both instances
      check("R1", "main reset value", {24'd0, value}, 32'h5A);
      check("R1", "hp reset value", {24'd0, b_value}, 32'h0F);
      check("R1", "ovf/unf in reset", {30'd0, ovf, unf}, 32'd0);
      check_red(8'h5A);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VECS[i];
         sw_req = v.req; sw_is_wr = v.wr; sw_wdata = v.wd; sw_wmask = v.wm;
         hw_we = v.we; hw_wdata = v.hd; hw_set = v.st; hw_clr = v.cl;
         cnt_inc = v.inc; cnt_inc_step = v.istep; cnt_dec = v.dec;
         #1;
         check("R11", "sw_acc_pulse", {31'd0, acc}, {31'd0, v.ea});
         check("R11", "sw_mod_pulse", {31'd0, mod}, {31'd0, v.em});
         @(negedge clk);
         check(vtag[i], "value", {24'd0, value}, {24'd0, v.ev});
         check("R8", "ovf_pulse", {31'd0, ovf}, {31'd0, v.eo});
         check("R8", "unf_pulse", {31'd0, unf}, {31'd0, v.eu});
         check_red(v.ev);
         idle_all();
      end

      // Hardware-precedence instance, directed
      // R3/R4: active-low write beats a one-clear software write
      b_we_n = 0; b_hd = 8'h3C; b_req = 1; b_wr = 1; b_wd = 8'hFF; b_wm = 8'hFF;
      @(negedge clk);
      check("R3", "hw write beats sw (hw prio)", {24'd0, b_value}, 32'h3C);
      idle_all();
      // R2: write-one-clear mode
      b_req = 1; b_wr = 1; b_wd = 8'h0C; b_wm = 8'hFF;
      @(negedge clk);
      check("R2", "one-clear write", {24'd0, b_value}, 32'h30);
      idle_all();
      // R5: disabled set input ignored
      b_set = 1; b_clr = 1;
      @(negedge clk);
      check("R5", "disabled set/clear ignored", {24'd0, b_value}, 32'h30);
      idle_all();
      // R7: constant unit step
      b_inc = 1;
      @(negedge clk);
      check("R7", "unit increment", {24'd0, b_value}, 32'h31);
      idle_all();
      // R3: count beats software when hardware has precedence
      b_inc = 1; b_req = 1; b_wr = 1; b_wd = 8'h01; b_wm = 8'hFF;
      @(negedge clk);
      check("R3", "count beats sw write", {24'd0, b_value}, 32'h32);
      idle_all();
      // R9: read without clearing leaves value; R11 no modify strobe
      b_req = 1; b_wr = 0;
      #1;
      check("R11", "hp read mod strobe", {31'd0, b_mod}, 32'd0);
      @(negedge clk);
      check("R9", "read with clearing disabled", {24'd0, b_value}, 32'h32);
      idle_all();
      // R4: write enable high (inactive) does nothing
      b_we_n = 1; b_hd = 8'hEE;
      @(negedge clk);
      check("R4", "inactive-high enable ignored", {24'd0, b_value}, 32'h32);
      idle_all();

      // R1: asynchronous reset mid-run
      #1 rst_n = 1'b0;
      #1;
      check("R1", "async reset main", {24'd0, value}, 32'h5A);
      check("R1", "async reset hp", {24'd0, b_value}, 32'h0F);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule